// File: doc/BRIEF.md
# Vector Priority Arbiter with Task Threshold

This block is the local interrupt decision point for one core. Interrupt sources present 8-bit vector numbers. The vector number is also the priority: larger numbers win. The upper nibble of a vector selects one of sixteen priority classes. The block keeps two 256-bit bit maps:

- a pending map of vectors that have been requested but not yet taken;
- an in-service map of vectors the core has taken but not yet retired.

Software programs a task threshold register. From that register and the highest in-service vector, the block derives a processor priority value. Every cycle the block picks the largest pending vector. It offers that vector to the core only when the vector's class is strictly above the class of the processor priority.

The core takes the offered vector by pulsing an acknowledge. On that edge the vector leaves the pending map and enters the in-service map. When the handler finishes, software signals end of interrupt. This retires the highest-numbered vector in service, which lowers the processor priority again and lets waiting lower-class vectors through. Vectors 0 to 15 are reserved and are never recorded.

Top module: `vpa_top`

## Requirements
- R1: After synchronous active-low reset, `tpr_q` and `ppr_q` read 0, no vector is pending or in service, and `irq_valid` is 0.
- R2: A request whose vector is below 16 (class 0) is dropped: it is never recorded and never offered.
- R3: When `irq_valid` is 1, `irq_vec` equals the highest-numbered vector in the pending map.
- R4: When `tpr_we` is high at a clock edge, `tpr_q` shows `tpr_wdata` from the next cycle onward. The class is `tpr_q[7:4]` and the subclass is `tpr_q[3:0]`.
- R5: `ppr_q` equals `tpr_q` when `tpr_q[7:4]` is at least the class of the highest in-service vector. Otherwise it equals that class in bits 7:4 with 0 in bits 3:0. With nothing in service, `ppr_q` equals `tpr_q`.
- R6: `irq_valid` is 1 exactly when some vector is pending and the class of the highest pending vector is strictly greater than `ppr_q[7:4]`. A threshold class of 15 therefore blocks every vector, and a threshold of 0 passes every valid vector.
- R7: `irq_ack` with `irq_valid` high moves the offered vector from the pending map to the in-service map at that clock edge. `irq_ack` while `irq_valid` is low has no effect.
- R8: An `eoi_we` pulse clears the highest-numbered in-service vector. With nothing in service it changes nothing.
- R9: Requesting a vector that is already pending merges into the existing entry. A single acknowledge removes it completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A vector request is present this cycle |
| req_vec | input | 8 | Requested vector number |
| tpr_we | input | 1 | Write strobe for the task threshold register |
| tpr_wdata | input | 8 | New threshold: class in 7:4, subclass in 3:0 |
| tpr_q | output | 8 | Current task threshold register |
| ppr_q | output | 8 | Derived processor priority (read only) |
| irq_valid | output | 1 | A vector is offered to the core |
| irq_vec | output | 8 | Offered vector number |
| irq_ack | input | 1 | Core takes the offered vector |
| eoi_we | input | 1 | End-of-interrupt strobe |

## Verification
The checker assumes the following about the inputs:
- every strobe is sampled only at a rising edge;
- `irq_ack` may arrive in any cycle, but counts only while `irq_valid` is high;
- a threshold write and an end of interrupt may coincide with an acknowledge.

The bench drives all inputs one step after the falling edge, so nothing changes at the sampling edge. The random stimulus mixes several things: reserved and valid vectors, repeated requests, acknowledges in cycles with and without an offer, end-of-interrupt strobes against both empty and busy in-service maps, and threshold writes skewed toward low classes so that delivery stays frequent. Directed steps pin down the class-15 block, the strict greater-than comparison at equal classes, and the merge of duplicate requests.

// File: rtl/vpa_pkg.sv
// Package: shared widths and helpers for the vector priority arbiter.
// Assumes vectors are VEC_W bits wide with the class in the top CLS_W bits.
package vpa_pkg;
    localparam int VEC_W = 8;
    localparam int CLS_W = 4;
    localparam int NVEC  = 1 << VEC_W;
    localparam int SUB_W = VEC_W - CLS_W;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    // Extract the priority class (upper bits) of a vector
    function automatic cls_t cls_of(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction
endpackage

// File: rtl/vpa_msb_find.sv
// Module: vpa_msb_find
// Finds the highest set bit of an N-bit map and reports its index.
// Assumes N is a power of two; idx is 0 when no bit is set.
module vpa_msb_find #(
    parameter int N = 256,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward so the last (highest) set bit wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vpa_ppr_calc.sv
// Module: vpa_ppr_calc
// Derives the processor priority from the task threshold and the top in-service vector.
// Assumes isr_top is meaningful only when isr_any is high.
module vpa_ppr_calc
    import vpa_pkg::*;
(
    input  vec_t tpr,
    input  logic isr_any,
    input  vec_t isr_top,
    output vec_t ppr
);
    cls_t isr_cls;

    // Class of the top in-service vector, or 0 when none is in service
    always_comb isr_cls = isr_any ? cls_of(isr_top) : '0;

    // Keep the threshold unless the in-service class sits above it
    always_comb begin
        if (cls_of(tpr) >= isr_cls) ppr = tpr;
        else                        ppr = {isr_cls, {SUB_W{1'b0}}};
    end
endmodule

// File: rtl/vpa_top.sv
// Module: vpa_top
// Local interrupt arbiter: pending and in-service vector maps, task threshold,
// class gating, acknowledge transfer and end-of-interrupt retirement.
// Assumes single-cycle strobes; ack is honoured only while irq_valid is high.
module vpa_top
    import vpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    output logic [VEC_W-1:0] tpr_q,
    output logic [VEC_W-1:0] ppr_q,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             eoi_we
);
    localparam int MIN_VEC = 1 << SUB_W;

    logic [NVEC-1:0] irr_q, isr_q;
    logic [NVEC-1:0] set_mask, ack_mask, eoi_mask;
    logic            irr_any, isr_any;
    vec_t            irr_top, isr_top;
    logic            req_ok, take;

    vpa_msb_find #(.N(NVEC)) u_irr_find (.bits(irr_q), .any(irr_any), .idx(irr_top));
    vpa_msb_find #(.N(NVEC)) u_isr_find (.bits(isr_q), .any(isr_any), .idx(isr_top));

    vpa_ppr_calc u_ppr (.tpr(tpr_q), .isr_any(isr_any), .isr_top(isr_top), .ppr(ppr_q));

    // Offer the top pending vector only above the processor priority class
    always_comb irq_valid = irr_any && (cls_of(irr_top) > cls_of(ppr_q));
    always_comb irq_vec   = irr_top;

    // Qualify incoming requests and acknowledges
    always_comb req_ok = req_valid && (req_vec >= vec_t'(MIN_VEC));
    always_comb take   = irq_valid && irq_ack;

    // Build one-hot update masks for this cycle
    always_comb begin
        set_mask = '0;
        ack_mask = '0;
        eoi_mask = '0;
        if (req_ok)             set_mask[req_vec] = 1'b1;
        if (take)               ack_mask[irr_top] = 1'b1;
        if (eoi_we && isr_any)  eoi_mask[isr_top] = 1'b1;
    end

    // Pending map: clear the taken vector, then record any new request
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= (irr_q & ~ack_mask) | set_mask;
    end

    // In-service map: retire the top entry on EOI, enter the taken vector
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~eoi_mask) | ack_mask;
    end

    // Task threshold register
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_q <= '0;
        else if (tpr_we) tpr_q <= tpr_wdata;
    end
endmodule

// File: rtl/vpa_top_chk.sv
// Module: vpa_top_chk
// Port-level properties of vpa_top, attached by bind.
// Assumes the same clock and synchronous active-low reset as the arbiter.
module vpa_top_chk
    import vpa_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tpr_we,
    input logic [VEC_W-1:0] tpr_wdata,
    input logic [VEC_W-1:0] tpr_q,
    input logic [VEC_W-1:0] ppr_q,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack
);
    // R2: reserved class-0 vectors are never offered
    a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (cls_of(irq_vec) != '0));

    // R6: an offered vector always lies above the processor priority class
    a_r6_above_ppr: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (cls_of(irq_vec) > cls_of(ppr_q)));

    // R4: a threshold write appears on the next cycle
    a_r4_tpr_load: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_we |=> (tpr_q == $past(tpr_wdata)));

    // R5: the processor priority never drops below the threshold class
    a_r5_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cls_of(ppr_q) >= cls_of(tpr_q));

    // R7: taking a vector raises the processor priority to at least its class
    a_r7_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> (cls_of(ppr_q) >= $past(cls_of(irq_vec))));
endmodule

bind vpa_top vpa_top_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tpr_we    (tpr_we),
    .tpr_wdata (tpr_wdata),
    .tpr_q     (tpr_q),
    .ppr_q     (ppr_q),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack)
);

// File: tb/vpa_top_tb.sv
// Bench: vpa_top_tb. Directed corners plus seeded random stimulus,
// checked each cycle against a bit-map model built from the requirements.
module vpa_top_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, tpr_we, irq_ack, eoi_we;
    logic [7:0] req_vec, tpr_wdata;
    logic [7:0] tpr_q, ppr_q, irq_vec;
    logic       irq_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [255:0] irr_m, isr_m;
    logic [7:0]   tpr_m;

    always #4 clk = ~clk;

    vpa_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_q(tpr_q), .ppr_q(ppr_q),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ack(irq_ack), .eoi_we(eoi_we)
    );

    function automatic int top_of(input logic [255:0] m);
        int t = -1;
        for (int i = 0; i < 256; i++) if (m[i]) t = i;
        return t;
    endfunction

    function automatic logic [7:0] ppr_model();
        int t = top_of(isr_m);
        logic [3:0] c = (t < 0) ? 4'd0 : 4'(t >> 4);
        return (tpr_m[7:4] >= c) ? tpr_m : {c, 4'h0};
    endfunction

    function automatic bit valid_model();
        int t = top_of(irr_m);
        return (t >= 0) && (4'(t >> 4) > ppr_model() >> 4);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model (called mid-cycle)
    task automatic check_outputs();
        check("R4 tpr_q", int'(tpr_q), int'(tpr_m));
        check("R5 ppr_q", int'(ppr_q), int'(ppr_model()));
        check("R6 irq_valid", int'(irq_valid), int'(valid_model()));
        if (valid_model()) check("R3 irq_vec", int'(irq_vec), top_of(irr_m));
    endtask

    // One cycle: check at negedge, drive inputs, advance the model, wait posedge
    task automatic step(input bit rv, input logic [7:0] rvec, input bit tw,
                        input logic [7:0] td, input bit ack, input bit eoi);
        int ti, ts;
        logic [255:0] irr_n, isr_n;
        @(negedge clk);
        check_outputs();
        req_valid = rv; req_vec = rvec; tpr_we = tw; tpr_wdata = td;
        irq_ack = ack; eoi_we = eoi;
        irr_n = irr_m; isr_n = isr_m;
        ti = top_of(irr_m); ts = top_of(isr_m);
        if (ack && valid_model()) begin irr_n[ti] = 1'b0; isr_n[ti] = 1'b1; end
        if (eoi && ts >= 0) isr_n[ts] = 1'b0;
        if (rv && rvec >= 8'd16) irr_n[rvec] = 1'b1;
        if (tw) tpr_m = td;
        irr_m = irr_n; isr_m = isr_n;
        @(posedge clk);
    endtask

    task automatic idle();
        step(1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        irr_m = '0; isr_m = '0; tpr_m = '0;
        rst_n = 1'b0; req_valid = 0; req_vec = 0; tpr_we = 0; tpr_wdata = 0;
        irq_ack = 0; eoi_we = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 tpr", int'(tpr_q), 0);
        check("R1 ppr", int'(ppr_q), 0);
        check("R1 valid", int'(irq_valid), 0);

        // R2: reserved vectors dropped
        step(1'b1, 8'd5, 0, 0, 0, 0);
        step(1'b1, 8'd15, 0, 0, 0, 0);
        idle();
        @(negedge clk); check("R2 reserved dropped", int'(irq_valid), 0);

        // R7: ack without an offer does nothing
        step(0, 0, 0, 0, 1'b1, 0);
        // R8: EOI with nothing in service ignored
        step(0, 0, 0, 0, 0, 1'b1);
        @(negedge clk); check("R8 empty eoi ppr", int'(ppr_q), 0);

        // R9: duplicate request, one ack clears it
        step(1'b1, 8'h20, 0, 0, 0, 0);
        step(1'b1, 8'h20, 0, 0, 0, 0);
        @(negedge clk); check("R3 offered 0x20", int'(irq_vec), 32);
        step(0, 0, 0, 0, 1'b1, 0);
        @(negedge clk);
        check("R9 merged cleared", int'(irq_valid), 0);
        check("R7 ppr raised", int'(ppr_q), 8'h20);
        step(0, 0, 0, 0, 0, 1'b1);
        @(negedge clk); check("R8 retired", int'(ppr_q), 0);

        // R6: threshold class equal to the vector class blocks it
        step(0, 0, 1'b1, 8'h35, 0, 0);
        step(1'b1, 8'h3F, 0, 0, 0, 0);
        @(negedge clk); check("R6 equal class blocked", int'(irq_valid), 0);
        step(1'b1, 8'h40, 0, 0, 0, 0);
        @(negedge clk); check("R6 higher class passes", int'(irq_vec), 8'h40);

        // R6: class 15 blocks everything
        step(1'b1, 8'hFF, 1'b1, 8'hF0, 0, 0);
        @(negedge clk); check("R6 class15 blocks", int'(irq_valid), 0);

        // R5: nested service, then threshold below in-service class
        step(0, 0, 1'b1, 8'h00, 0, 0);
        step(0, 0, 0, 0, 1'b1, 0);
        @(negedge clk); check("R5 ppr from isr", int'(ppr_q), 8'hF0);
        step(0, 0, 0, 0, 1'b1, 1'b1);
        step(0, 0, 0, 0, 0, 1'b1);
        step(0, 0, 0, 0, 0, 1'b1);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            bit rv  = ($urandom_range(0, 9) < 6);
            logic [7:0] v = 8'($urandom_range(0, 255));
            bit tw  = ($urandom_range(0, 19) == 0);
            logic [7:0] td = {4'($urandom_range(0, 6)), 4'($urandom_range(0, 15))};
            bit ack = ($urandom_range(0, 1) == 1);
            bit eoi = ($urandom_range(0, 9) < 2);
            step(rv, v, tw, td, ack, eoi);
        end
        @(negedge clk); check_outputs();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule